// File: doc/BRIEF.md
# Pipelined Full-Tree Haar Packet Transform (16 points)

This block takes a vector of 16 signed samples and passes it through a complete Haar wavelet packet tree. Every node of the tree is split into a sum branch and a difference branch at every level. The block has no multipliers. Each of the four levels is a bank of add/subtract butterflies followed by one pipeline register. A direction bit travels with each vector and selects one of two operations:

- **Analysis:** splits the vector into packet coefficients. Each butterfly result is halved with an arithmetic right shift.
- **Synthesis:** rebuilds a vector from its coefficients without any scaling.

Because of this split in scaling, synthesis followed by analysis returns the original vector bit for bit. Vectors may be presented on back-to-back cycles, and the direction may change from one vector to the next. Samples are packed into flat buses, with sample k at bits [k*W +: W].

Top module: `haar_packet_xform`

## Requirements
- R1: A vector accepted with `in_valid` high at a rising edge appears at the output with `out_valid` high exactly 4 rising edges later. `out_valid` is high for one cycle per accepted vector.
- R2: With `in_dir`=0 (analysis), the four levels use block sizes 16, 8, 4 and then 2. Within each block of size B, the pair at offsets 2i and 2i+1 produces two results:
  - offset i receives floor((a+b)/2);
  - offset B/2+i receives floor((a-b)/2).
  
  As a consequence, a constant input c gives c at sample 0 and zero elsewhere, and an all-zero input gives an all-zero output.
- R3: With `in_dir`=1 (synthesis), the four levels use block sizes 2, 4, 8 and then 16. Within each block of size B, let L be the value at offset i and H the value at offset B/2+i. Offset 2i receives L+H and offset 2i+1 receives L-H. An input with value v at sample 0 and zero elsewhere therefore gives v on all 16 outputs.
- R4: If every synthesis input fits in W-4 signed bits, feeding the synthesis output back in with `in_dir`=0 reproduces the original vector exactly.
- R5: The direction is captured with each vector. Consecutive vectors with different directions are each transformed in their own direction.
- R6: While `rst_n` is low, `out_valid` is 0 and `out_data` is 0.
- R7: While `out_valid` is 0, `out_data` keeps its last value. `in_data` and `in_dir` have no effect when `in_valid` is 0.
- R8: For synthesis inputs within W-4 signed bits, no intermediate sum overflows: after level j (counting from 0) every sample fits in W-4+j+1 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input vector strobe |
| in_dir | input | 1 | Direction: 0 analysis, 1 synthesis |
| in_data | input | N*W | 16 signed samples, sample k at [k*W +: W] |
| out_valid | output | 1 | Result strobe |
| out_data | output | N*W | 16 signed result samples, same packing |

## Verification
Every result is due 4 rising edges after the edge that accepts its vector. The bench drives inputs on falling edges and samples on the falling edge that follows the fourth rising edge. It also checks that `out_valid` is still low one falling edge earlier.

For streams of consecutive vectors, the bench checks result k at the falling edge k+4 counted from the first drive, so each result is compared in its own one-cycle window. Hold behaviour is checked over several idle cycles after the last result, while the bench changes the ignored inputs.

// File: rtl/hpx_pkg.sv
package hpx_pkg;
    typedef enum logic {
        HPX_ANALYSIS  = 1'b0,
        HPX_SYNTHESIS = 1'b1
    } hpx_dir_e;
endpackage

// File: rtl/hpx_split.sv
// One analysis level: pairs within each block are combined into a halved sum
// (low half of block) and a halved difference (high half of block).
module hpx_split #(
    parameter int N   = 16,
    parameter int W   = 16,
    parameter int BLK = 16
) (
    input  logic [N-1:0][W-1:0] din,
    output logic [N-1:0][W-1:0] dout
);
    localparam int HALF = BLK / 2;
    localparam int NBLK = N / BLK;

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        for (genvar i = 0; i < HALF; i++) begin : g_pair
            logic signed [W:0] sum_w;
            logic signed [W:0] dif_w;
            assign sum_w = $signed({din[b*BLK+2*i][W-1], din[b*BLK+2*i]})
                         + $signed({din[b*BLK+2*i+1][W-1], din[b*BLK+2*i+1]});
            assign dif_w = $signed({din[b*BLK+2*i][W-1], din[b*BLK+2*i]})
                         - $signed({din[b*BLK+2*i+1][W-1], din[b*BLK+2*i+1]});
            assign dout[b*BLK+i]      = W'(sum_w >>> 1);
            assign dout[b*BLK+HALF+i] = W'(dif_w >>> 1);
        end
    end
endmodule

// File: rtl/hpx_merge.sv
// One synthesis level: low/high halves of each block are recombined into
// interleaved sum/difference pairs, no scaling.
module hpx_merge #(
    parameter int N   = 16,
    parameter int W   = 16,
    parameter int BLK = 2
) (
    input  logic [N-1:0][W-1:0] din,
    output logic [N-1:0][W-1:0] dout
);
    localparam int HALF = BLK / 2;
    localparam int NBLK = N / BLK;

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        for (genvar i = 0; i < HALF; i++) begin : g_pair
            assign dout[b*BLK+2*i]   = din[b*BLK+i] + din[b*BLK+HALF+i];
            assign dout[b*BLK+2*i+1] = din[b*BLK+i] - din[b*BLK+HALF+i];
        end
    end
endmodule

// File: rtl/haar_packet_xform.sv
module haar_packet_xform #(
    parameter int N = 16,
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic           in_dir,
    input  logic [N*W-1:0] in_data,
    output logic           out_valid,
    output logic [N*W-1:0] out_data
);
    import hpx_pkg::*;

    localparam int STG = $clog2(N);

    typedef struct packed {
        logic [STG-1:0]                 vld;
        logic [STG-1:0]                 dir;
        logic [STG-1:0][N-1:0][W-1:0]   dat;
    } pipe_t;

    pipe_t st_d, st_q;

    logic [STG-1:0][N-1:0][W-1:0] stg_in;
    logic [STG-1:0][N-1:0][W-1:0] spl_out;
    logic [STG-1:0][N-1:0][W-1:0] mrg_out;
    logic [STG-1:0]               stg_vld;
    hpx_dir_e                     stg_dir [STG];
    logic [STG-1:0][N-1:0][W-1:0] pipe_dat;

    for (genvar j = 0; j < STG; j++) begin : g_stage
        if (j == 0) begin : g_first
            assign stg_in[j]  = in_data;
            assign stg_vld[j] = in_valid;
            assign stg_dir[j] = hpx_dir_e'(in_dir);
        end else begin : g_next
            assign stg_in[j]  = st_q.dat[j-1];
            assign stg_vld[j] = st_q.vld[j-1];
            assign stg_dir[j] = hpx_dir_e'(st_q.dir[j-1]);
        end

        hpx_split #(.N(N), .W(W), .BLK(N >> j)) u_split (
            .din  (stg_in[j]),
            .dout (spl_out[j])
        );

        hpx_merge #(.N(N), .W(W), .BLK(2 << j)) u_merge (
            .din  (stg_in[j]),
            .dout (mrg_out[j])
        );
    end

    always_comb begin
        st_d = st_q;
        for (int j = 0; j < STG; j++) begin
            st_d.vld[j] = stg_vld[j];
            if (stg_vld[j]) begin
                st_d.dir[j] = stg_dir[j];
                st_d.dat[j] = (stg_dir[j] == HPX_SYNTHESIS) ? mrg_out[j] : spl_out[j];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pipe_dat  = st_q.dat;
    assign out_valid = st_q.vld[STG-1];
    assign out_data  = st_q.dat[STG-1];
endmodule

// File: rtl/hpx_checker.sv
module hpx_checker #(
    parameter int N = 16,
    parameter int W = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         in_valid,
    input logic                         in_dir,
    input logic [N*W-1:0]               in_data,
    input logic                         out_valid,
    input logic [N*W-1:0]               out_data,
    input logic [$clog2(N)-1:0][N-1:0][W-1:0] pipe_dat
);
    localparam int STG   = $clog2(N);
    localparam int SYN_W = W - STG;

    function automatic logic fits(logic [W-1:0] v, int bits);
        logic signed [W-1:0] t;
        t = $signed(v) >>> (bits - 1);
        return (t == '0) || (t == '1);
    endfunction

    logic [STG-1:0] vld_sr, zero_sr, rng_sr;
    logic           in_ok;
    logic [STG-1:0] stg_ok;

    always_comb begin
        in_ok = 1'b1;
        for (int k = 0; k < N; k++) begin
            if (!fits(in_data[k*W +: W], SYN_W)) in_ok = 1'b0;
        end
    end

    always_comb begin
        stg_ok = '1;
        for (int j = 0; j < STG; j++) begin
            for (int k = 0; k < N; k++) begin
                if (!fits(pipe_dat[j][k], SYN_W + j + 1)) stg_ok[j] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_sr  <= '0;
            zero_sr <= '0;
            rng_sr  <= '0;
        end else begin
            vld_sr  <= {vld_sr[STG-2:0], in_valid};
            zero_sr <= {zero_sr[STG-2:0], in_valid && (in_data == '0)};
            rng_sr  <= {rng_sr[STG-2:0], in_valid && in_dir && in_ok};
        end
    end

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vld_sr[STG-1]); // R1

    AST_ZERO_MAPS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && zero_sr[STG-1]) |-> (out_data == '0)); // R2

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0)); // R6

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data)); // R7

    for (genvar j = 0; j < STG; j++) begin : g_ovf
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            rng_sr[j] |-> stg_ok[j]); // R8
    end
endmodule

bind haar_packet_xform hpx_checker #(.N(N), .W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_dir    (in_dir),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .pipe_dat  (pipe_dat)
);

// File: tb/tb_haar_packet_xform.sv
module tb_haar_packet_xform;
    localparam int N        = 16;
    localparam int W        = 16;
    localparam int STG      = 4;
    localparam int CLK_PER  = 10;

    typedef logic signed [W-1:0] smp_t;
    typedef smp_t vec_t [N];

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic           in_dir = 1'b0;
    logic [N*W-1:0] in_data = '0;
    logic           out_valid;
    logic [N*W-1:0] out_data;

    int n_chk = 0;
    int n_fail = 0;
    int unsigned seed = 32'h1234_5678;
    bit done = 1'b0;

    haar_packet_xform #(.N(N), .W(W)) dut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_dir (in_dir),
        .in_data (in_data), .out_valid (out_valid), .out_data (out_data)
    );

    always #(CLK_PER/2) clk = ~clk;

    function automatic int rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return int'(seed >> 8);
    endfunction

    function automatic vec_t rnd_vec(input bit narrow);
        vec_t v;
        for (int k = 0; k < N; k++) begin
            if (narrow) v[k] = smp_t'((rnd() % 4096) - 2048);
            else        v[k] = smp_t'(rnd());
        end
        return v;
    endfunction

    function automatic vec_t model_analysis(input vec_t x);
        vec_t cur = x;
        vec_t nxt;
        for (int lvl = 0; lvl < STG; lvl++) begin
            int blk = N >> lvl;
            for (int b = 0; b < N / blk; b++) begin
                for (int i = 0; i < blk / 2; i++) begin
                    int a = cur[b*blk+2*i];
                    int c = cur[b*blk+2*i+1];
                    nxt[b*blk+i]         = smp_t'((a + c) >>> 1);
                    nxt[b*blk+blk/2+i]   = smp_t'((a - c) >>> 1);
                end
            end
            cur = nxt;
        end
        return cur;
    endfunction

    function automatic vec_t model_synthesis(input vec_t x);
        vec_t cur = x;
        vec_t nxt;
        for (int lvl = 0; lvl < STG; lvl++) begin
            int blk = 2 << lvl;
            for (int b = 0; b < N / blk; b++) begin
                for (int i = 0; i < blk / 2; i++) begin
                    int l = cur[b*blk+i];
                    int h = cur[b*blk+blk/2+i];
                    nxt[b*blk+2*i]   = smp_t'(l + h);
                    nxt[b*blk+2*i+1] = smp_t'(l - h);
                end
            end
            cur = nxt;
        end
        return cur;
    endfunction

    function automatic logic [N*W-1:0] pack(input vec_t v);
        logic [N*W-1:0] p;
        for (int k = 0; k < N; k++) p[k*W +: W] = v[k];
        return p;
    endfunction

    function automatic vec_t unpack(input logic [N*W-1:0] p);
        vec_t v;
        for (int k = 0; k < N; k++) v[k] = smp_t'(p[k*W +: W]);
        return v;
    endfunction

    task automatic chk_bit(input string req, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, got, exp);
        end
    endtask

    task automatic chk_vec(input string req, input vec_t got, input vec_t exp);
        n_chk++;
        for (int k = 0; k < N; k++) begin
            if (got[k] !== exp[k]) begin
                n_fail++;
                $display("FAIL %s: sample %0d got %0d expected %0d", req, k, got[k], exp[k]);
                break;
            end
        end
    endtask

    // Drive one vector, return the result sampled 4 edges later.
    task automatic run_one(input vec_t v, input logic dir, input string req, output vec_t res);
        @(negedge clk);
        in_valid = 1'b1; in_dir = dir; in_data = pack(v);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk_bit({req, " R1 early"}, out_valid, 1'b0);
        @(negedge clk);
        chk_bit({req, " R1 due"}, out_valid, 1'b1);
        res = unpack(out_data);
    endtask

    task automatic t_reset();
        chk_bit("R6 valid in reset", out_valid, 1'b0);
        chk_bit("R6 data in reset", out_data == '0, 1'b1);
    endtask

    task automatic t_analysis();
        vec_t v, r, e;
        for (int k = 0; k < N; k++) v[k] = 16'sd100;
        e = '{default: '0}; e[0] = 16'sd100;
        run_one(v, 1'b0, "R2 dc", r);
        chk_vec("R2 dc", r, e);
        v = '{default: '0};
        run_one(v, 1'b0, "R2 zero", r);
        chk_vec("R2 zero", r, v);
        for (int k = 0; k < N; k++) v[k] = smp_t'((k % 2 == 0) ? -7 : 4);
        run_one(v, 1'b0, "R2 odd negative", r);
        chk_vec("R2 odd negative", r, model_analysis(v));
        for (int n = 0; n < 4; n++) begin
            v = rnd_vec(1'b0);
            run_one(v, 1'b0, "R2 random", r);
            chk_vec("R2 random", r, model_analysis(v));
        end
    endtask

    task automatic t_synthesis();
        vec_t v, r, e;
        v = '{default: '0}; v[0] = 16'sd5;
        for (int k = 0; k < N; k++) e[k] = 16'sd5;
        run_one(v, 1'b1, "R3 impulse", r);
        chk_vec("R3 impulse", r, e);
        v = '{default: '0}; v[9] = -16'sd3;
        run_one(v, 1'b1, "R3 single coef", r);
        chk_vec("R3 single coef", r, model_synthesis(v));
        for (int n = 0; n < 3; n++) begin
            v = rnd_vec(1'b1);
            run_one(v, 1'b1, "R3 random", r);
            chk_vec("R3 random", r, model_synthesis(v));
        end
    endtask

    task automatic t_roundtrip();
        vec_t v, s, r;
        for (int n = 0; n < 5; n++) begin
            if (n == 0)      for (int k = 0; k < N; k++) v[k] = -16'sd2048;
            else if (n == 1) for (int k = 0; k < N; k++) v[k] = 16'sd2047;
            else             v = rnd_vec(1'b1);
            run_one(v, 1'b1, "R4 synth", s);
            chk_vec("R8 synth range", s, model_synthesis(v));
            run_one(s, 1'b0, "R4 analysis", r);
            chk_vec("R4 round trip", r, v);
        end
    endtask

    task automatic t_stream();
        vec_t v [4];
        logic d [4];
        for (int n = 0; n < 4; n++) begin
            v[n] = rnd_vec(1'b1);
            d[n] = logic'(n % 2);
        end
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            if (c >= 4) begin
                chk_bit("R5 stream valid", out_valid, 1'b1);
                chk_vec("R5 stream data", unpack(out_data),
                        d[c-4] ? model_synthesis(v[c-4]) : model_analysis(v[c-4]));
            end
            if (c < 4) begin
                in_valid = 1'b1; in_dir = d[c]; in_data = pack(v[c]);
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        chk_bit("R1 single pulse", out_valid, 1'b0);
    endtask

    task automatic t_hold();
        vec_t v, r, held;
        v = rnd_vec(1'b0);
        run_one(v, 1'b0, "R7 setup", r);
        held = r;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            in_valid = 1'b0; in_dir = ~in_dir; in_data = pack(rnd_vec(1'b0));
            chk_bit("R7 idle valid", out_valid, 1'b0);
        end
        chk_vec("R7 held data", unpack(out_data), held);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_analysis();
        t_synthesis();
        t_roundtrip();
        t_stream();
        t_hold();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule